// File: doc/BRIEF.md
# Folded Band-Pass FIR with One Time-Shared Multiplier

This block filters one stream of 16-bit signed samples through a 107-tap band-pass FIR. The system clock runs 64 times faster than the sample rate. For a nominal 150 kHz sample rate, the pass band sits at about 1.6–10 kHz. Each accepted sample opens a slot of 64 clock cycles, and one multiplier serves the whole slot.

The impulse response is even-symmetric, so two taps that mirror each other share one coefficient. A bank of 53 pre-adders sums each mirrored pair of delayed samples. The middle delayed sample has no partner and passes through on its own. During the slot, one product per cycle goes into a wide accumulator. At the end of the slot the sum is rounded and saturated to 16 bits and shown with a one-cycle strobe.

The coefficients come from a 64-entry lookup table that a package function fills. Changing that function changes the filter response. A complex input stream needs two copies of the block, one for the real part and one for the imaginary part.

Top module: `symfir_filter`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first result is produced.
- R2: The coefficient table has 64 entries. Entry k, for k from 0 to 53, holds ((251·k + 97) mod 4001) − 2000, and entries 54 to 63 hold 0. Tap j (0 = newest) uses entry min(j, 106 − j).
- R3: Each result equals the sum, over taps j = 0..106, of sample(n−j) × h(j). The sum is rounded by adding 16384 and shifting right arithmetically by 15.
- R4: The delay line advances only on a cycle with `in_valid` high. Idle cycles of any length between samples leave the filter history unchanged.
- R5: For a sample taken at rising edge E, `out_valid` is high for exactly one cycle, after rising edge E+64. It is never high otherwise.
- R6: `out_sample` keeps its value on every cycle where `out_valid` is low.
- R7: A rounded sum above 32767 gives 32767, and a rounded sum below −32768 gives −32768.
- R8: A sample that arrives while a slot is running is accepted and restarts the slot. The result of the interrupted slot is never shown, and the next pulse comes 64 edges after the newer sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 64 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: `in_sample` holds a new sample |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe: `out_sample` holds a new result |
| out_sample | output | 16 | Signed, rounded and saturated filter output |

## Verification
The checker watches four things on every cycle:
- the single-cycle width of the output strobe;
- its exact distance of 64 edges from the last accepted sample;
- the suppression of a result when a new sample restarts the slot;
- the output value holding steady between strobes.

Only the bench's scenarios can show that the arithmetic is right. A direct-form model checks each result. The scenarios cover:
- an impulse that exposes each coefficient through the mirrored mapping;
- inputs built to drive the sum past both rails;
- long idle gaps that must not disturb the history;
- a sample injected in the middle of a slot.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    localparam int SMP_W  = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 15;
    localparam int ACC_W  = 40;

    typedef logic signed [SMP_W-1:0]      smp_t;
    typedef logic signed [SMP_W:0]        fold_t;
    typedef logic signed [COEF_W-1:0]     coef_t;
    typedef logic signed [SMP_W+COEF_W:0] prod_t;
    typedef logic signed [ACC_W-1:0]      acc_t;

    // One product travelling from the multiplier to the accumulator.
    typedef struct packed {
        logic  live;
        prod_t value;
    } term_t;

    localparam acc_t ACC_HI = acc_t'((2 ** (SMP_W - 1)) - 1);
    localparam acc_t ACC_LO = -acc_t'(2 ** (SMP_W - 1));

    // Coefficient generator: replace this body to retune the filter.
    function automatic coef_t coef_lut(int idx, int used);
        int v;
        if (idx >= used) begin
            v = 0;
        end else begin
            v = ((idx * 251 + 97) % 4001) - 2000;
        end
        return coef_t'(v);
    endfunction

    // Round half up, drop the fraction, clamp to the sample range.
    function automatic smp_t round_sat(acc_t a);
        acc_t r;
        r = (a + (acc_t'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
        if (r > ACC_HI) begin
            r = ACC_HI;
        end else if (r < ACC_LO) begin
            r = ACC_LO;
        end
        return r[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/symfir_slot_ctrl.sv
module symfir_slot_ctrl #(
    parameter int SLOT  = 64,
    parameter int NCOEF = 54,
    parameter int SEL_W = $clog2(SLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [SEL_W-1:0] idx,
    output logic             term_live,
    output logic             finish
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(SLOT - 1);

    logic             busy_q;
    logic [SEL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign idx       = cnt_q;
    assign term_live = busy_q && (int'(cnt_q) < NCOEF) && !start;
    assign finish    = busy_q && (cnt_q == LAST) && !start;

endmodule

// File: rtl/symfir_taps.sv
module symfir_taps
    import symfir_pkg::*;
#(
    parameter int NTAPS = 107,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  smp_t             din,
    input  logic [SEL_W-1:0] sel,
    output fold_t            fold_out
);

    localparam int NPAIRS = NTAPS / 2;
    localparam int NCOEF  = NPAIRS + 1;

    smp_t  line_q [NTAPS];
    fold_t folds  [NCOEF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) begin
                line_q[i] <= '0;
            end
        end else if (shift_en) begin
            line_q[0] <= din;
            for (int i = 1; i < NTAPS; i++) begin
                line_q[i] <= line_q[i-1];
            end
        end
    end

    // Pre-adders: each pair of mirrored taps folds into one operand.
    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        assign folds[g] = fold_t'(line_q[g]) + fold_t'(line_q[NTAPS-1-g]);
    end
    assign folds[NPAIRS] = fold_t'(line_q[NPAIRS]);

    always_comb begin
        fold_out = '0;
        if (int'(sel) < NCOEF) begin
            fold_out = folds[sel];
        end
    end

endmodule

// File: rtl/symfir_coef_rom.sv
module symfir_coef_rom
    import symfir_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NCOEF = 54,
    parameter int SEL_W = $clog2(DEPTH)
) (
    input  logic [SEL_W-1:0] sel,
    output coef_t            coef
);

    coef_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign rom[g] = coef_lut(g, NCOEF);
    end

    assign coef = rom[sel];

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac
    import symfir_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  term_live,
    input  fold_t fold,
    input  coef_t coef,
    input  logic  finish,
    output smp_t  y,
    output logic  y_valid
);

    term_t term_q;
    acc_t  acc_q;
    smp_t  y_q;
    logic  yv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            term_q <= '0;
            acc_q  <= '0;
            y_q    <= '0;
            yv_q   <= 1'b0;
        end else begin
            yv_q <= finish;
            if (clear) begin
                term_q <= '0;
                acc_q  <= '0;
            end else begin
                term_q.live  <= term_live;
                term_q.value <= prod_t'(fold) * prod_t'(coef);
                if (term_q.live) begin
                    acc_q <= acc_q + acc_t'(term_q.value);
                end
            end
            if (finish) begin
                y_q <= round_sat(acc_q);
            end
        end
    end

    assign y       = y_q;
    assign y_valid = yv_q;

endmodule

// File: rtl/symfir_filter.sv
module symfir_filter
    import symfir_pkg::*;
#(
    parameter int NTAPS = 107,
    parameter int SLOT  = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_sample,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_sample
);

    localparam int NCOEF = NTAPS / 2 + 1;
    localparam int SEL_W = $clog2(SLOT);

    logic [SEL_W-1:0] idx;
    logic             term_live;
    logic             finish;
    fold_t            fold;
    coef_t            coef;
    smp_t             y;

    symfir_slot_ctrl #(.SLOT(SLOT), .NCOEF(NCOEF), .SEL_W(SEL_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (in_valid),
        .idx       (idx),
        .term_live (term_live),
        .finish    (finish)
    );

    symfir_taps #(.NTAPS(NTAPS), .SEL_W(SEL_W)) taps_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_sample),
        .sel      (idx),
        .fold_out (fold)
    );

    symfir_coef_rom #(.DEPTH(SLOT), .NCOEF(NCOEF), .SEL_W(SEL_W)) rom_i (
        .sel  (idx),
        .coef (coef)
    );

    symfir_mac mac_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (in_valid),
        .term_live (term_live),
        .fold      (fold),
        .coef      (coef),
        .finish    (finish),
        .y         (y),
        .y_valid   (out_valid)
    );

    assign out_sample = y;

endmodule

// File: rtl/symfir_chk.sv
module symfir_chk #(
    parameter int SLOT = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [15:0] out_sample
);

    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (in_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q && gap_q == 16'(SLOT)));

    p_restart_drop_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !out_valid);

    p_hold_value_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));

endmodule

bind symfir_filter symfir_chk #(.SLOT(SLOT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/symfir_filter_tb_top.sv
module symfir_filter_tb_top;

    localparam int NT = 107;
    localparam int MID = 53;
    localparam int NVEC = 16;
    localparam logic signed [15:0] VEC [NVEC] = '{
        16'sd100, -16'sd250, 16'sd32767, -16'sd32768,
        16'sd0, 16'sd1, -16'sd1, 16'sd12000,
        -16'sd9000, 16'sd4321, 16'sd777, -16'sd20000,
        16'sd30000, -16'sd5, 16'sd2500, -16'sd32000
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    logic signed [15:0] hist [NT];

    always #10 clk = ~clk;

    symfir_filter dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails = fails + 1;
            $display("FAIL R5 watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", checks + 1, fails);
            $finish;
        end
    end

    function automatic longint coef_b(int j);
        int k;
        k = (j <= MID) ? j : (NT - 1 - j);
        return longint'(((k * 251 + 97) % 4001) - 2000);
    endfunction

    function automatic longint ref_out();
        longint acc;
        longint r;
        acc = 0;
        for (int j = 0; j < NT; j++) begin
            acc = acc + longint'(hist[j]) * coef_b(j);
        end
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < NT; i++) hist[i] = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        check(out_sample == 16'sd0, "R1 data in reset", longint'(out_sample), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && out_sample == 16'sd0, "R1 after release",
              longint'(out_sample), 0);
    endtask

    task automatic send_only(input logic signed [15:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = x;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
    endtask

    task automatic await_result(input string tag, output longint got);
        longint exp;
        int early;
        exp = ref_out();
        early = 0;
        repeat (63) begin
            @(negedge clk);
            if (out_valid) early++;
        end
        check(early == 0, "R5 no early strobe", early, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R5 strobe at edge 64", longint'(out_valid), 1);
        check(longint'(out_sample) == exp, tag, longint'(out_sample), exp);
        got = longint'(out_sample);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 strobe width", longint'(out_valid), 0);
        check(longint'(out_sample) == exp, "R6 hold after strobe", longint'(out_sample), exp);
    endtask

    task automatic run_sample(input logic signed [15:0] x, input string tag, output longint got);
        send_only(x);
        await_result(tag, got);
    endtask

    initial begin
        longint got;
        int hits;
        logic signed [15:0] held;

        do_reset();

        // Vector table walk (R3)
        for (int v = 0; v < NVEC; v++) begin
            run_sample(VEC[v], "R3 vector table", got);
        end

        // Idle gap must not disturb history (R4, R6)
        held = out_sample;
        hits = 0;
        repeat (300) begin
            @(negedge clk);
            if (out_valid || out_sample != held) hits++;
        end
        check(hits == 0, "R6 idle hold", hits, 0);
        run_sample(16'sd1234, "R4 history kept over gap", got);

        // Impulse exposes every coefficient through the mirror mapping (R2)
        do_reset();
        run_sample(16'sd32767, "R2 impulse tap 0", got);
        for (int j = 1; j < NT; j++) begin
            run_sample(16'sd0, "R2 impulse tap", got);
        end
        run_sample(16'sd0, "R2 impulse flushed", got);
        check(got == 0, "R2 impulse flushed zero", got, 0);

        // Positive rail (R7)
        do_reset();
        for (int m = 0; m < NT; m++) begin
            run_sample((coef_b(NT - 1 - m) >= 0) ? 16'sd32767 : -16'sd32767,
                       "R3 ramp to rail", got);
        end
        check(got == 32767, "R7 positive clamp", got, 32767);

        // Negative rail (R7)
        do_reset();
        for (int m = 0; m < NT; m++) begin
            run_sample((coef_b(NT - 1 - m) >= 0) ? -16'sd32768 : 16'sd32767,
                       "R3 ramp to rail", got);
        end
        check(got == -32768, "R7 negative clamp", got, -32768);

        // Restart in mid slot (R8)
        do_reset();
        run_sample(16'sd5000, "R3 before restart", got);
        send_only(16'sd3000);
        hits = 0;
        repeat (20) begin
            @(negedge clk);
            if (out_valid) hits++;
        end
        send_only(-16'sd7000);
        check(hits == 0, "R8 no strobe before restart", hits, 0);
        await_result("R8 restarted result", got);

        // Reset in the middle of a slot (R1)
        send_only(16'sd9999);
        repeat (10) @(negedge clk);
        do_reset();
        hits = 0;
        repeat (80) begin
            @(negedge clk);
            if (out_valid) hits++;
        end
        check(hits == 0, "R1 slot aborted by reset", hits, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule